// File: doc/BRIEF.md
# Masked Scalar FP32 Multiply Unit

This unit multiplies the lowest single-precision element of two wide vector operands and builds a complete destination vector around the product. It is the execution end of a scalar multiply: decode, operand fetch and trap handling sit elsewhere. The unit accepts one operation per clock behind an input valid strobe and returns the result with a fixed two-cycle latency.

The operation takes one of three forms. The legacy form multiplies in place: the old destination is the first operand and every destination bit above 31 is kept. The plain three-operand form takes its upper lanes from source 1 and clears everything above bit 127. The masked three-operand form adds a one-bit mask on the low element. A masked-out element either keeps the old low word or is cleared. A rounding mode may be given with each operation. When it is not, the mode comes from a control-register field. Five IEEE exception flags come back with each result.

Top module: `fpmul_unit`

## Requirements
- R1: For an active product, `dest[31:0]` is the correctly rounded IEEE binary32 product of the two low words. Subnormal inputs and results are kept at full precision and are never flushed to zero.
- R2: In both three-operand forms (`form` 1, 2 or 3), `dest[127:32]` equals `src1[127:32]` and every bit from 128 up to `VEC_W-1` is zero.
- R3: In the legacy form (`form` 0), the first operand is `oldDest[31:0]` and `dest[VEC_W-1:32]` equals `oldDest[VEC_W-1:32]`. `src1` has no effect on the result.
- R4: The mask applies only when `form[1]` is 1. With `maskEn` 0 or `maskBit` 1, the product is written. With `maskEn` 1 and `maskBit` 0, the element is masked out: `zeroMask` 0 keeps `oldDest[31:0]`, `zeroMask` 1 writes zero, and all flags are 0.
- R5: The rounding mode is `rcOp` when `rcOverride` and `src2IsReg` are both 1, and `ctrlRc` otherwise. The encoding is 0 nearest-even, 1 toward negative infinity, 2 toward positive infinity, 3 toward zero.
- R6: A NaN operand returns that NaN with bit 22 set, and a NaN in the first operand wins. Infinity times zero returns 0xFFC00000. Either case with a signalling NaN, and infinity times zero, sets `flags[0]` (invalid).
- R7: If the rounded exponent exceeds the finite range, `flags[2]` (overflow) and `flags[4]` (inexact) are set. The result is infinity for nearest-even, for toward positive infinity when positive, and for toward negative infinity when negative. Otherwise it is the largest finite value of that sign.
- R8: `flags[4]` marks an inexact result. `flags[3]` (underflow) is set when the unrounded result is below 2^-126 and inexact. `flags[1]` (denormal) is set when either operand is subnormal.
- R9: `outValid` is high exactly two cycles after each cycle with `inValid` high, and back-to-back operations are accepted every cycle.
- R10: While `rstN` is low, `outValid`, `dest` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| form | input | 2 | 0 legacy, 1 plain three-operand, 2 or 3 masked three-operand |
| src1 | input | VEC_W | First source vector |
| src2 | input | VEC_W | Second source vector; only bits 31:0 are used |
| oldDest | input | VEC_W | Current destination contents |
| maskEn | input | 1 | A mask is in use (masked form only) |
| maskBit | input | 1 | Mask bit for the low element |
| zeroMask | input | 1 | 1 zeroes a masked-out element, 0 merges it |
| rcOverride | input | 1 | Per-operation rounding request |
| src2IsReg | input | 1 | Second source came from a register |
| rcOp | input | 2 | Per-operation rounding mode |
| ctrlRc | input | 2 | Rounding mode from the control register |
| outValid | output | 1 | Result valid |
| dest | output | VEC_W | Destination vector |
| flags | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge, and that every control input is at a known level on every edge, including idle cycles, because the pipeline registers load on every cycle. They also assume `VEC_W` is at least 128. The stimulus drives all inputs to defined values at each falling edge, including cycles with `inValid` low. It mixes random wide vectors with low words built to hit subnormals, values near the exponent limits, NaNs and infinities. It streams operations back to back with idle gaps at random.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

  localparam int FLAG_W   = 5;
  localparam int FLAG_INV = 0;
  localparam int FLAG_DEN = 1;
  localparam int FLAG_OVF = 2;
  localparam int FLAG_UNF = 3;
  localparam int FLAG_INX = 4;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef enum logic [1:0] {
    LOW_PROD  = 2'd0,
    LOW_KEEP  = 2'd1,
    LOW_CLEAR = 2'd2
  } lowSel_e;

  // strobes from control to datapath
  typedef struct packed {
    rnd_e    rnd;
    lowSel_e lowSel;
    logic    legacy;
  } mulCtrl_t;

  typedef struct packed {
    logic zero;
    logic den;
    logic inf;
    logic nan;
    logic snan;
  } fpClass_t;

  function automatic fpClass_t classify(input logic [31:0] v);
    fpClass_t c;
    c.zero = (v[30:23] == 8'h00) && (v[22:0] == '0);
    c.den  = (v[30:23] == 8'h00) && (v[22:0] != '0);
    c.inf  = (v[30:23] == 8'hFF) && (v[22:0] == '0);
    c.nan  = (v[30:23] == 8'hFF) && (v[22:0] != '0);
    c.snan = c.nan && !v[22];
    return c;
  endfunction

  function automatic logic [5:0] lead48(input logic [47:0] v);
    logic [5:0] cnt;
    logic found;
    cnt = 6'd48;
    found = 1'b0;
    for (int i = 47; i >= 0; i--) begin
      if (!found && v[i]) begin
        cnt = 6'(47 - i);
        found = 1'b1;
      end
    end
    return cnt;
  endfunction

endpackage

// File: rtl/fpmul_ctrl.sv
module fpmul_ctrl
  import fpmul_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic [1:0] form,
  input  logic     maskEn,
  input  logic     maskBit,
  input  logic     zeroMask,
  input  logic     rcOverride,
  input  logic     src2IsReg,
  input  logic [1:0] rcOp,
  input  logic [1:0] ctrlRc,
  output mulCtrl_t ctrl,
  output logic     outValid
);

  logic validS1;
  logic maskedOut;

  assign maskedOut = form[1] && maskEn && !maskBit;

  always_comb begin
    ctrl.legacy = (form == 2'b00);
    ctrl.rnd    = (rcOverride && src2IsReg) ? rnd_e'(rcOp) : rnd_e'(ctrlRc);
    if (maskedOut) ctrl.lowSel = zeroMask ? LOW_CLEAR : LOW_KEEP;
    else           ctrl.lowSel = LOW_PROD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validS1  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      validS1  <= inValid;
      outValid <= validS1;
    end
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R9
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);

endmodule

// File: rtl/fpmul_dp.sv
module fpmul_dp
  import fpmul_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulCtrl_t          ctrl,
  input  logic [VEC_W-1:0]  src1,
  input  logic [VEC_W-1:0]  src2,
  input  logic [VEC_W-1:0]  oldDest,
  output logic [VEC_W-1:0]  dest,
  output logic [FLAG_W-1:0] flags
);

  localparam int MAN_W  = 24;
  localparam int PROD_W = 2 * MAN_W;

  // ---------------- stage 1: unpack, multiply, specials ----------------
  logic [31:0] opA, opB;
  fpClass_t    clsA, clsB;
  logic [MAN_W-1:0] manA, manB;
  logic [7:0]  effA, effB;
  logic [PROD_W-1:0] prodNext;
  logic signed [10:0] expNext;
  logic        signNext, specHit, infZero, specInv, specDen;
  logic [31:0] specVal;
  logic [VEC_W-1:32] threeOpUpper, upperNext;

  assign opA  = ctrl.legacy ? oldDest[31:0] : src1[31:0];
  assign opB  = src2[31:0];
  assign clsA = classify(opA);
  assign clsB = classify(opB);
  assign manA = {|opA[30:23], opA[22:0]};
  assign manB = {|opB[30:23], opB[22:0]};
  assign effA = (opA[30:23] == 8'h00) ? 8'd1 : opA[30:23];
  assign effB = (opB[30:23] == 8'h00) ? 8'd1 : opB[30:23];
  assign prodNext = PROD_W'(manA) * PROD_W'(manB);
  assign expNext  = $signed({3'b000, effA}) + $signed({3'b000, effB}) - 11'sd126;
  assign signNext = opA[31] ^ opB[31];
  assign infZero  = (clsA.inf && clsB.zero) || (clsA.zero && clsB.inf);
  assign specHit  = clsA.nan || clsB.nan || clsA.inf || clsB.inf || clsA.zero || clsB.zero;
  assign specInv  = clsA.snan || clsB.snan || infZero;
  assign specDen  = clsA.den || clsB.den;

  always_comb begin
    if (clsA.nan)                 specVal = opA | 32'h0040_0000;
    else if (clsB.nan)            specVal = opB | 32'h0040_0000;
    else if (infZero)             specVal = 32'hFFC0_0000;
    else if (clsA.inf || clsB.inf) specVal = {signNext, 8'hFF, 23'd0};
    else                          specVal = {signNext, 31'd0};
  end

  generate
    if (VEC_W > 128) begin : g_clear
      assign threeOpUpper = {{(VEC_W-128){1'b0}}, src1[127:32]};
    end else begin : g_noclear
      assign threeOpUpper = src1[VEC_W-1:32];
    end
  endgenerate

  assign upperNext = ctrl.legacy ? oldDest[VEC_W-1:32] : threeOpUpper;

  logic [PROD_W-1:0]  prodQ;
  logic signed [10:0] expQ;
  logic               signQ, specHitQ, specInvQ, specDenQ;
  logic [31:0]        specValQ, oldLowQ;
  mulCtrl_t           ctrlQ;
  logic [VEC_W-1:32]  upperQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ    <= '0;
      expQ     <= '0;
      signQ    <= 1'b0;
      specHitQ <= 1'b0;
      specInvQ <= 1'b0;
      specDenQ <= 1'b0;
      specValQ <= '0;
      oldLowQ  <= '0;
      ctrlQ    <= '0;
      upperQ   <= '0;
    end else begin
      prodQ    <= prodNext;
      expQ     <= expNext;
      signQ    <= signNext;
      specHitQ <= specHit;
      specInvQ <= specInv;
      specDenQ <= specDen;
      specValQ <= specVal;
      oldLowQ  <= oldDest[31:0];
      ctrlQ    <= ctrl;
      upperQ   <= upperNext;
    end
  end

  // ---------------- stage 2: normalize, round, assemble ----------------
  logic [5:0]  lz;
  logic [PROD_W-1:0] norm, shifted;
  logic signed [10:0] expN, sh;
  logic        lost, guardBit, stickyBit, inc, tiny, bigOvf, ovf, inexact, toInf;
  logic [22:0] mant;
  logic [7:0]  pExp;
  logic [30:0] rounded;
  logic [31:0] prodBits, lowNext;
  logic [FLAG_W-1:0] prodFlags, flagsNext;

  always_comb begin
    lz       = lead48(prodQ);
    norm     = prodQ << lz;
    expN     = expQ - $signed({5'b00000, lz});
    sh       = 11'sd1 - expN;
    shifted  = norm;
    lost     = 1'b0;
    pExp     = expN[7:0];
    tiny     = 1'b0;
    if (expN < 11'sd1) begin
      tiny = 1'b1;
      pExp = 8'h00;
      if (sh >= 11'sd48) begin
        shifted = '0;
        lost    = |norm;
      end else begin
        shifted = norm >> sh[5:0];
        lost    = |(norm & ((48'd1 << sh[5:0]) - 48'd1));
      end
    end
    mant      = shifted[46:24];
    guardBit  = shifted[23];
    stickyBit = (|shifted[22:0]) | lost;
    inexact   = guardBit | stickyBit;
    bigOvf    = expN > 11'sd254;
    case (ctrlQ.rnd)
      RND_NEAR: inc = guardBit && (stickyBit || mant[0]);
      RND_DOWN: inc = signQ && inexact;
      RND_UP:   inc = !signQ && inexact;
      default:  inc = 1'b0;
    endcase
    rounded = {pExp, mant} + 31'(inc);
    ovf     = bigOvf || (rounded[30:23] == 8'hFF);
    toInf   = (ctrlQ.rnd == RND_NEAR) || (ctrlQ.rnd == RND_UP && !signQ) ||
              (ctrlQ.rnd == RND_DOWN && signQ);

    prodFlags = '0;
    prodFlags[FLAG_DEN] = specDenQ;
    if (specHitQ) begin
      prodBits = specValQ;
      prodFlags[FLAG_INV] = specInvQ;
    end else if (ovf) begin
      prodBits = toInf ? {signQ, 8'hFF, 23'd0} : {signQ, 8'hFE, 23'h7F_FFFF};
      prodFlags[FLAG_OVF] = 1'b1;
      prodFlags[FLAG_INX] = 1'b1;
    end else begin
      prodBits = {signQ, rounded};
      prodFlags[FLAG_INX] = inexact;
      prodFlags[FLAG_UNF] = tiny && inexact;
    end

    case (ctrlQ.lowSel)
      LOW_PROD: lowNext = prodBits;
      LOW_KEEP: lowNext = oldLowQ;
      default:  lowNext = '0;
    endcase
    flagsNext = (ctrlQ.lowSel == LOW_PROD) ? prodFlags : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dest  <= '0;
      flags <= '0;
    end else begin
      dest  <= {upperQ, lowNext};
      flags <= flagsNext;
    end
  end

  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.lowSel != LOW_PROD) |=> (flags == '0));

  // R4
  zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.lowSel == LOW_CLEAR) |=> (dest[31:0] == 32'd0));

  // R7
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[FLAG_OVF] |-> flags[FLAG_INX]);

  // R8
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[FLAG_UNF] |-> flags[FLAG_INX]);

  generate
    if (VEC_W > 128) begin : g_hi_chk
      // R2
      high_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.legacy |=> ##1 (dest[VEC_W-1:128] == '0));
    end
  endgenerate

endmodule

// File: rtl/fpmul_unit.sv
module fpmul_unit
  import fpmul_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       form,
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] oldDest,
  input  logic             maskEn,
  input  logic             maskBit,
  input  logic             zeroMask,
  input  logic             rcOverride,
  input  logic             src2IsReg,
  input  logic [1:0]       rcOp,
  input  logic [1:0]       ctrlRc,
  output logic             outValid,
  output logic [VEC_W-1:0] dest,
  output logic [4:0]       flags
);

  mulCtrl_t ctrl;

  fpmul_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .form       (form),
    .maskEn     (maskEn),
    .maskBit    (maskBit),
    .zeroMask   (zeroMask),
    .rcOverride (rcOverride),
    .src2IsReg  (src2IsReg),
    .rcOp       (rcOp),
    .ctrlRc     (ctrlRc),
    .ctrl       (ctrl),
    .outValid   (outValid)
  );

  fpmul_dp #(.VEC_W(VEC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .src1    (src1),
    .src2    (src2),
    .oldDest (oldDest),
    .dest    (dest),
    .flags   (flags)
  );

endmodule

// File: tb/tb_fpmul_unit.sv
module tb_fpmul_unit;

  localparam int W = 512;

  logic clk, rstN, inValid, maskEn, maskBit, zeroMask, rcOverride, src2IsReg;
  logic [1:0] form, rcOp, ctrlRc;
  logic [W-1:0] src1, src2, oldDest, dest;
  logic outValid;
  logic [4:0] flags;

  fpmul_unit #(.VEC_W(W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .form(form),
    .src1(src1), .src2(src2), .oldDest(oldDest),
    .maskEn(maskEn), .maskBit(maskBit), .zeroMask(zeroMask),
    .rcOverride(rcOverride), .src2IsReg(src2IsReg), .rcOp(rcOp), .ctrlRc(ctrlRc),
    .outValid(outValid), .dest(dest), .flags(flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  bit e0V = 0, e1V = 0;
  logic [W-1:0] e0D = '0, e1D = '0;
  logic [4:0] e0F = '0, e1F = '0;
  string e0T = "", e1T = "";

  // behavioural binary32 product; flags {inx, unf, ovf, den, inv}
  function automatic void refMul(input logic [31:0] a, input logic [31:0] b,
                                 input logic [1:0] rm,
                                 output logic [31:0] r, output logic [4:0] fl);
    bit s, nanA, nanB, infA, infB, zA, zB, infZ, tiny, inexact, up;
    longint ma, mb, m, kept, rem, half;
    int ea, eb, e, p, x, q, k, cls, biased;
    s    = a[31] ^ b[31];
    nanA = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nanB = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    infA = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    infB = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    zA   = (a[30:0] == 0);
    zB   = (b[30:0] == 0);
    infZ = (infA && zB) || (zA && infB);
    fl = '0;
    fl[1] = ((a[30:23] == 0) && !zA) || ((b[30:23] == 0) && !zB);
    fl[0] = (nanA && !a[22]) || (nanB && !b[22]) || infZ;
    if (nanA) begin r = a | 32'h0040_0000; return; end
    if (nanB) begin r = b | 32'h0040_0000; return; end
    if (infZ) begin r = 32'hFFC0_0000; return; end
    if (infA || infB) begin r = {s, 8'hFF, 23'd0}; return; end
    if (zA || zB) begin r = {s, 31'd0}; return; end
    ma = (a[30:23] != 0) ? (longint'(a[22:0]) + 64'h80_0000) : longint'(a[22:0]);
    mb = (b[30:23] != 0) ? (longint'(b[22:0]) + 64'h80_0000) : longint'(b[22:0]);
    ea = ((a[30:23] != 0) ? int'(a[30:23]) : 1) - 150;
    eb = ((b[30:23] != 0) ? int'(b[30:23]) : 1) - 150;
    m = ma * mb;
    e = ea + eb;
    p = 0;
    for (int i = 0; i < 48; i++) if (m[i]) p = i;
    x = p + e;
    q = (x - 23 > -149) ? x - 23 : -149;
    k = q - e;
    if (k <= 0) begin
      kept = m << (-k);
      cls = 0;
    end else if (k > 49) begin
      kept = 0;
      cls = 1;
    end else begin
      kept = m >> k;
      rem  = m - (kept << k);
      half = 64'd1 << (k - 1);
      cls  = (rem == 0) ? 0 : (rem < half) ? 1 : (rem == half) ? 2 : 3;
    end
    inexact = (cls != 0);
    case (rm)
      2'd0: up = (cls == 3) || (cls == 2 && kept[0]);
      2'd1: up = s && inexact;
      2'd2: up = !s && inexact;
      default: up = 0;
    endcase
    if (up) kept = kept + 1;
    if (kept == (64'd1 << 24)) begin kept = kept >> 1; q = q + 1; end
    tiny = (x < -126);
    fl[4] = inexact;
    fl[3] = tiny && inexact;
    if (kept >= (64'd1 << 23)) begin
      biased = q + 150;
      if (biased >= 255) begin
        fl[2] = 1; fl[4] = 1;
        if (rm == 2'd0 || (rm == 2'd2 && !s) || (rm == 2'd1 && s)) r = {s, 8'hFF, 23'd0};
        else r = {s, 8'hFE, 23'h7F_FFFF};
      end else begin
        r = {s, biased[7:0], kept[22:0]};
      end
    end else begin
      r = {s, 8'd0, kept[22:0]};
    end
  endfunction

  function automatic logic [W-1:0] rand512();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] randOp();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: return r & 32'h807F_FFFF;
      1: return {r[31], 8'hFE - {6'd0, r[1:0]}, r[22:0]};
      2: return {r[31], 8'h01 + {6'd0, r[1:0]}, r[22:0]};
      3: return {r[31], 8'h40 + {3'd0, r[4:0]}, r[22:0]};
      4: return {r[31], 8'h3F, r[22:0]};
      default: return r;
    endcase
  endfunction

  task automatic compareOut();
    nChecks++;
    if (outValid !== e1V) begin
      nFails++;
      $display("FAIL R9 outValid got %b exp %b", outValid, e1V);
    end
    if (e1V) begin
      nChecks++;
      if (dest !== e1D) begin
        nFails++;
        $display("FAIL %s dest got %h exp %h", e1T, dest, e1D);
      end
      nChecks++;
      if (flags !== e1F) begin
        nFails++;
        $display("FAIL %s flags got %b exp %b", e1T, flags, e1F);
      end
    end
  endtask

  task automatic step(input bit v, input logic [1:0] fm,
                      input logic [W-1:0] s1, input logic [W-1:0] s2, input logic [W-1:0] od,
                      input bit mEn, input bit mBit, input bit zM,
                      input bit ovr, input bit isReg, input logic [1:0] rcO, input logic [1:0] crc,
                      input string tag);
    logic [1:0] rm;
    logic [31:0] aLow, r;
    logic [4:0] fl;
    logic [W-1:0] expD;
    bit masked;
    @(negedge clk);
    compareOut();
    e1V = e0V; e1D = e0D; e1F = e0F; e1T = e0T;
    inValid = v; form = fm; src1 = s1; src2 = s2; oldDest = od;
    maskEn = mEn; maskBit = mBit; zeroMask = zM;
    rcOverride = ovr; src2IsReg = isReg; rcOp = rcO; ctrlRc = crc;
    rm = (ovr && isReg) ? rcO : crc;
    aLow = (fm == 2'd0) ? od[31:0] : s1[31:0];
    refMul(aLow, s2[31:0], rm, r, fl);
    if (fm == 2'd0) expD = od;
    else begin
      expD = '0;
      expD[127:0] = s1[127:0];
    end
    masked = fm[1] && mEn && !mBit;
    if (masked) begin
      expD[31:0] = zM ? 32'd0 : od[31:0];
      fl = '0;
    end else begin
      expD[31:0] = r;
    end
    e0V = v; e0D = expD; e0F = fl; e0T = tag;
  endtask

  task automatic idle();
    step(0, 2'd1, '0, '0, '0, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R9");
  endtask

  // plain product with uppers randomized; the legacy form takes a from oldDest
  task automatic mulOp(input logic [1:0] fm, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] rm, input string tag);
    logic [W-1:0] s1, s2, od;
    s1 = rand512(); s2 = rand512(); od = rand512();
    s2[31:0] = b;
    if (fm == 2'd0) od[31:0] = a; else s1[31:0] = a;
    step(1, fm, s1, s2, od, 0, 0, 0, 0, 1, 2'd3, rm, tag);
  endtask

  task automatic maskOp(input bit mEn, input bit mBit, input bit zM, input string tag);
    logic [W-1:0] s1, s2, od;
    s1 = rand512(); s2 = rand512(); od = rand512();
    s1[31:0] = 32'h7F7F_FFFF; s2[31:0] = 32'h4000_0000;
    step(1, 2'd2, s1, s2, od, mEn, mBit, zM, 0, 0, 2'd0, 2'd0, tag);
  endtask

  initial begin
    begin : watchdog
      #2_000_000;
      if (!finished) begin
        nFails++;
        $display("FAIL R9 watchdog expired got hung exp done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    rstN = 0; inValid = 0; form = 2'd1; src1 = '0; src2 = '0; oldDest = '0;
    maskEn = 0; maskBit = 0; zeroMask = 0; rcOverride = 0; src2IsReg = 0;
    rcOp = 2'd0; ctrlRc = 2'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    nChecks++;
    if (outValid !== 1'b0 || dest !== '0 || flags !== '0) begin
      nFails++;
      $display("FAIL R10 reset got v=%b f=%b d=%h exp all zero", outValid, flags, dest);
    end
    rstN = 1;

    // R1 exact and rounded products in all modes
    mulOp(2'd1, 32'h3FC0_0000, 32'h4000_0000, 2'd0, "R1");
    for (int m = 0; m < 4; m++) mulOp(2'd1, 32'h3EAA_AAAB, 32'h4040_0000, 2'(m), "R1");
    for (int m = 0; m < 4; m++) mulOp(2'd1, 32'hBF80_0001, 32'h3F80_0003, 2'(m), "R1");
    // R8 subnormal inputs and results
    mulOp(2'd1, 32'h0000_0001, 32'h3F80_0000, 2'd0, "R8");
    mulOp(2'd1, 32'h0000_0003, 32'h3F00_0000, 2'd0, "R8");
    mulOp(2'd1, 32'h0080_0000, 32'h3F7F_FFFF, 2'd0, "R8");
    mulOp(2'd1, 32'h0040_0000, 32'h0040_0000, 2'd2, "R8");
    mulOp(2'd1, 32'h0000_0001, 32'h4B00_0000, 2'd1, "R1");
    // R7 overflow by mode and sign
    for (int m = 0; m < 4; m++) begin
      mulOp(2'd1, 32'h7F7F_FFFF, 32'h4000_0000, 2'(m), "R7");
      mulOp(2'd1, 32'hFF7F_FFFF, 32'h4000_0000, 2'(m), "R7");
    end
    mulOp(2'd1, 32'h7F7F_FFFF, 32'h3F80_0001, 2'd0, "R7");
    // R6 NaN and invalid cases
    mulOp(2'd1, 32'h7FA0_0000, 32'h3F80_0000, 2'd0, "R6");
    mulOp(2'd1, 32'h3F80_0000, 32'hFFC1_2345, 2'd0, "R6");
    mulOp(2'd1, 32'h7FC0_0001, 32'hFF80_0001, 2'd0, "R6");
    mulOp(2'd1, 32'h7F80_0000, 32'h0000_0000, 2'd0, "R6");
    mulOp(2'd1, 32'h7F80_0000, 32'hC000_0000, 2'd0, "R6");
    mulOp(2'd1, 32'h8000_0000, 32'h40A0_0000, 2'd0, "R6");
    // R3 legacy form, src1 irrelevant
    mulOp(2'd0, 32'h4049_0FDB, 32'h4049_0FDB, 2'd0, "R3");
    mulOp(2'd0, 32'hC120_0000, 32'h3DCC_CCCD, 2'd3, "R3");
    // R2 plain and masked form uppers
    mulOp(2'd1, 32'h4000_0000, 32'h4000_0000, 2'd0, "R2");
    mulOp(2'd3, 32'h4000_0000, 32'h4000_0000, 2'd0, "R2");
    // R4 mask behaviour
    maskOp(1, 0, 0, "R4");
    maskOp(1, 0, 1, "R4");
    maskOp(1, 1, 0, "R4");
    maskOp(0, 0, 1, "R4");
    begin
      logic [W-1:0] s1, s2, od;
      s1 = rand512(); s2 = rand512(); od = rand512();
      // R4 mask ignored outside the masked form
      step(1, 2'd1, s1, s2, od, 1, 0, 1, 0, 0, 2'd0, 2'd0, "R4");
      step(1, 2'd0, s1, s2, od, 1, 0, 1, 0, 0, 2'd0, 2'd0, "R4");
      // R5 override honoured only for a register source
      s1[31:0] = 32'h3EAA_AAAB; s2[31:0] = 32'hC040_0000;
      step(1, 2'd2, s1, s2, od, 0, 0, 0, 1, 1, 2'd2, 2'd0, "R5");
      step(1, 2'd2, s1, s2, od, 0, 0, 0, 1, 0, 2'd2, 2'd0, "R5");
      step(1, 2'd2, s1, s2, od, 0, 0, 0, 0, 1, 2'd1, 2'd3, "R5");
      step(1, 2'd2, s1, s2, od, 0, 0, 0, 1, 1, 2'd1, 2'd3, "R5");
    end
    idle();
    // R9 back-to-back stream with random gaps; R1 R5 random mix
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] s1, s2, od;
      s1 = rand512(); s2 = rand512(); od = rand512();
      s1[31:0] = randOp(); s2[31:0] = randOp(); od[31:0] = randOp();
      if ($urandom % 6 == 0) idle();
      step(1, 2'($urandom), s1, s2, od, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), "R1_R5_R9");
    end
    repeat (3) idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule